// File: doc/BRIEF.md
# Elementary Cellular Automaton Row

This block keeps a one-dimensional row of binary cells, where each cell is alive (1) or dead (0). On every simulation tick it advances the whole row by one generation. An 8-bit rule gives each cell its next state, looked up from the cell's three-cell neighbourhood. The row goes straight out as a vector, for example to drive a bank of LEDs.

A synchronous reset loads the row from a starting-pattern input, such as board switches. The same reset samples the rule input into an internal holding register. The simulation uses that held rule until the next reset, so an operator can dial a new rule while the row keeps running. The row width is a parameter.

The bit numbering is fixed. Cell `WIDTH-1` is the leftmost cell. The left neighbour of cell i is cell i+1, and its right neighbour is cell i-1.

Top module: `eca_row`

## Requirements
- R1: While `rst` is high at a rising clock edge, the row takes the value of `seed_in` at that edge, and this is visible on `cells` after the edge.
- R2: While `rst` is high at a rising clock edge, the rule used by later generations becomes the value of `rule_in` at that edge.
- R3: Changes on `rule_in` while `rst` is low have no effect on any later generation.
- R4: On a tick, the next state of each cell is bit `{left, center, right}` of the held rule, where left is the most significant bit of the 3-bit index.
- R5: Positions beyond either end of the row read as constant 0 when neighbourhoods are formed.
- R6: On a clock edge with `tick` low and `rst` low, `cells` keeps its value.
- R7: All cells update together from the previous generation. No cell sees a neighbour's new value within the same step.
- R8: With rule 137, which maps patterns 000, 011 and 111 to 1, a 6-cell row 110011 (written leftmost first) becomes 100010 after one tick.
- R9: When `rst` and `tick` are both high at an edge, the reset load wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; loads the row and samples the rule |
| tick | input | 1 | One-cycle enable that advances one generation |
| seed_in | input | WIDTH | Starting row loaded on reset |
| rule_in | input | 8 | Rule sampled on reset |
| cells | output | WIDTH | Current generation, bit WIDTH-1 is the leftmost cell |

## Verification
Rule 0x01 applied to an all-zero row, and then to the all-one row it produces, separates zero padding at the ends from any other boundary value. Rule 0xF0 copies each cell's left neighbour, so it acts as a one-place shift. On the pattern 0xA5A5 that shift exposes any cell that reads an already-updated neighbour. The six-cell 137 case pins the index order of the neighbourhood. Forty random rule and seed pairs, each run for several generations against a software model, cover the remaining rule bits. Between these runs the rule input is changed with reset low and the tick is withheld, to show that neither disturbs the row.

// File: rtl/eca_pkg.sv
package eca_pkg;

    localparam int RULE_W = 8;
    localparam int HOOD_W = 3;

    typedef logic [RULE_W-1:0] rule_t;

    typedef struct packed {
        logic left;
        logic center;
        logic right;
    } hood_t;

    function automatic logic apply_rule(input rule_t rule, input hood_t hood);
        logic [HOOD_W-1:0] idx;
        idx = {hood.left, hood.center, hood.right};
        return rule[idx];
    endfunction

endpackage

// File: rtl/eca_rule_latch.sv
module eca_rule_latch
    import eca_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rule_t rule_in,
    output rule_t rule_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rule_q <= rule_in;
        end
    end

endmodule

// File: rtl/eca_cell.sv
module eca_cell
    import eca_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  seed_bit,
    input  rule_t rule,
    input  logic  nb_left,
    input  logic  nb_right,
    output logic  state
);

    hood_t hood;

    always_comb begin
        hood.left   = nb_left;
        hood.center = state;
        hood.right  = nb_right;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= seed_bit;
        end else if (tick) begin
            state <= apply_rule(rule, hood);
        end
    end

endmodule

// File: rtl/eca_row.sv
module eca_row
    import eca_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [WIDTH-1:0] seed_in,
    input  logic [7:0]       rule_in,
    output logic [WIDTH-1:0] cells
);

    localparam int PAD_W = WIDTH + 2;

    rule_t            rule_q;
    logic [WIDTH-1:0] row;
    logic [PAD_W-1:0] padded;

    eca_rule_latch u_rule (
        .clk     (clk),
        .rst     (rst),
        .rule_in (rule_in),
        .rule_q  (rule_q)
    );

    // zero padding at both ends of the row
    assign padded = {1'b0, row, 1'b0};

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        eca_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .seed_bit (seed_in[i]),
            .rule     (rule_q),
            .nb_left  (padded[i+2]),
            .nb_right (padded[i]),
            .state    (row[i])
        );
    end

    assign cells = row;

    a_r1_seed_load: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cells == $past(seed_in));

    a_r2_rule_capture: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rule_q == $past(rule_in));

    a_r3_rule_held: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(rule_q));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cells));

endmodule

// File: tb/eca_row_tb.sv
module eca_row_tb;

    localparam int W = 16;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic [W-1:0] seed_in = '0;
    logic [7:0]   rule_in = '0;
    logic [W-1:0] cells;
    logic [5:0]   seed6 = 6'b110011;
    logic [7:0]   rule6 = 8'd137;
    logic [5:0]   cells6;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    item_t        sb_q[$];
    logic [W-1:0] model_row;
    logic [7:0]   model_rule;

    always #4 clk = ~clk;

    eca_row #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .tick(tick),
        .seed_in(seed_in), .rule_in(rule_in), .cells(cells)
    );

    eca_row #(.WIDTH(6)) u_dut_w6 (
        .clk(clk), .rst(rst), .tick(tick),
        .seed_in(seed6), .rule_in(rule6), .cells(cells6)
    );

    function automatic logic [W-1:0] ref_step(input logic [W-1:0] r, input logic [7:0] rl);
        logic [W-1:0] n;
        for (int i = 0; i < W; i++) begin
            logic l, c, rr;
            l  = (i == W-1) ? 1'b0 : r[i+1];
            c  = r[i];
            rr = (i == 0) ? 1'b0 : r[i-1];
            n[i] = rl[{l, c, rr}];
        end
        return n;
    endfunction

    task automatic push(input logic [W-1:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_reset(input logic [W-1:0] s, input logic [7:0] rl, input logic with_tick);
        @(negedge clk);
        rst = 1'b1; tick = with_tick; seed_in = s; rule_in = rl;
        @(posedge clk); #1;
        model_row = s; model_rule = rl;
        push(model_row, with_tick ? "R9" : "R1");
        @(negedge clk);
        rst = 1'b0; tick = 1'b0;
    endtask

    task automatic do_step(input string tag);
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk); #1;
        model_row = ref_step(model_row, model_rule);
        push(model_row, tag);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_idle(input logic [7:0] new_rule);
        @(negedge clk);
        tick = 1'b0; rule_in = new_rule;
        @(posedge clk); #1;
        push(model_row, "R6");
    endtask

    // monitor: pops expected items and compares with the output
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (cells !== it.exp) begin
                fails++;
                $display("FAIL %s cells=%h expected=%h", it.tag, cells, it.exp);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);

        // R1 reset state, R8 six-cell rule 137 case
        do_reset(16'h1234, 8'd137, 1'b0);
        do_step("R4");
        @(negedge clk);
        checks++;
        if (cells6 !== 6'b100010) begin
            fails++;
            $display("FAIL R8 cells6=%b expected=%b", cells6, 6'b100010);
        end

        // R5 zero padding at both ends
        do_reset(16'h0000, 8'h01, 1'b0);
        do_step("R5");
        do_step("R5");

        // R7 simultaneous update: rule F0 shifts by one place
        do_reset(16'hA5A5, 8'hF0, 1'b0);
        do_step("R7");
        checks++;
        if (model_row !== 16'h52D2) begin
            fails++;
            $display("FAIL R7 model=%h expected=%h", model_row, 16'h52D2);
        end

        // R3 rule input change without reset, R6 idle hold
        do_reset(16'h0F0F, 8'd30, 1'b0);
        do_idle(8'd255);
        do_step("R3");
        do_idle(8'd0);
        do_step("R3");

        // R9 reset wins over tick
        do_reset(16'hBEEF, 8'd90, 1'b1);
        do_step("R4");

        // R2 and R4: random rules and seeds against the model
        for (int k = 0; k < 40; k++) begin
            do_reset(W'($urandom), 8'($urandom), 1'b0);
            do_step("R2");
            for (int s = 0; s < 5; s++) begin
                if (s == 2) do_idle(8'($urandom));
                do_step("R4");
            end
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule